// File: doc/BRIEF.md
# Floating-Point Rounding Decision Unit

This block takes one unpacked floating-point mantissa per strobe and produces its rounded form. The two lowest mantissa bits carry the guard and round positions, and a separate sticky input summarises any bits lost further down. The unit drops the guard and round bits with a two-bit right shift. It then decides whether to add one at the new least significant position, using the sign and a two-bit rounding mode. It reports whether the result was inexact and whether it was rounded up.

The same mode decode also drives a second output. That output tells the caller whether a result that overflows its exponent range should become infinity or the largest finite magnitude. The unit does not touch exponents. If a carry runs out of the top of the shifted mantissa, the value is handed back unnormalised in an extra top bit, and the caller adjusts. Results are registered and appear one cycle after the input strobe, together with an output strobe.

Top module: `rnd_decision_unit`

## Requirements
- R1: While reset is asserted, and at the first sampling after reset, `out_valid`, `out_mant`, `out_inexact`, `out_rounded_up` and `out_to_inf` are all zero.
- R2: `out_valid` is high exactly in the cycle after each cycle in which `in_valid` is high. When `in_valid` is low, every result output keeps its previous value.
- R3: If `in_mant[1]` (guard), `in_mant[0]` (round) and `in_sticky` are all zero, then `out_inexact` and `out_rounded_up` are 0 and `out_mant` equals `in_mant >> 2`.
- R4: If any of guard, round or sticky is 1, `out_inexact` is 1 in every mode.
- R5: In mode 2'b00 (round to nearest), the value is incremented only when guard is 1 and at least one of round, sticky or `in_mant[2]` (the least significant bit after the shift) is 1. An exact tie is therefore rounded to an even result.
- R6: In mode 2'b01 (toward zero), the value is never incremented.
- R7: In mode 2'b10 (toward plus infinity), an inexact value is incremented when `in_sign` is 0 and left alone when `in_sign` is 1.
- R8: In mode 2'b11 (toward minus infinity), an inexact value is incremented when `in_sign` is 1 and left alone when `in_sign` is 0.
- R9: `out_mant` is MANT_W-1 bits wide and equals `{1'b0, in_mant[MANT_W-1:2]}` plus the increment. The carry ripples across the full width. An all-ones input that is rounded up yields only the top bit of `out_mant` set (the value 2.0). `out_rounded_up` is 1 exactly when the increment was applied.
- R10: `out_to_inf` is 1 in mode 2'b00, 0 in mode 2'b01, equal to `!in_sign` in mode 2'b10 and equal to `in_sign` in mode 2'b11, whatever the mantissa.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Sign of the value, 1 for negative |
| in_mant | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits below round |
| in_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_mant | output | MANT_W-1 | Shifted and possibly incremented mantissa, top bit is the carry |
| out_inexact | output | 1 | Any discarded bit was nonzero |
| out_rounded_up | output | 1 | Increment was applied |
| out_to_inf | output | 1 | Overflow should become infinity rather than the largest finite value |

## Verification
The bench aims at the tie cases of nearest mode. A design that ignored the post-shift LSB would truncate odd ties instead of making them even. A design that treated a lone guard bit as enough would round every tie up. Sticky-only and round-only inputs check that these bits set inexact without forcing an increment in nearest mode. They would expose a design that derived inexact from guard alone. Each directed mode is run with both signs, which catches swapped plus and minus infinity decodes in both the increment and the overflow outputs. An all-ones mantissa checks that the carry reaches the extra top bit rather than wrapping to zero.

// File: rtl/rnd_pkg.sv
// Shared types for the rounding decision unit.
// Assumes the mode field is exactly two bits wide.
package rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_POS_INF = 2'b10,
        RM_NEG_INF = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/rnd_mode_decode.sv
// Decodes the rounding mode once for both consumers.
// Produces a nearest-mode flag, a directed round-up enable for the
// given sign, and the overflow-to-infinity decision. Purely combinational.
module rnd_mode_decode
    import rnd_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      sign,
    output logic      is_nearest,
    output logic      directed_up,
    output logic      to_inf
);
    // Per-mode decode: directed modes round away from zero only for one sign.
    always_comb begin
        is_nearest  = 1'b0;
        directed_up = 1'b0;
        unique case (mode)
            RM_NEAREST: is_nearest  = 1'b1;
            RM_ZERO:    directed_up = 1'b0;
            RM_POS_INF: directed_up = ~sign;
            RM_NEG_INF: directed_up = sign;
            default:    directed_up = 1'b0;
        endcase
        to_inf = is_nearest | directed_up;
    end
endmodule

// File: rtl/rnd_incr_decide.sv
// Decides inexactness and whether to add one ulp.
// Assumes is_nearest and directed_up come from rnd_mode_decode
// and are never both set.
module rnd_incr_decide (
    input  logic guard,
    input  logic round,
    input  logic sticky,
    input  logic lsb,
    input  logic is_nearest,
    input  logic directed_up,
    output logic inexact,
    output logic incr
);
    // Increment rule: nearest with ties to even, otherwise the directed enable.
    always_comb begin
        inexact = guard | round | sticky;
        if (!inexact)
            incr = 1'b0;
        else if (is_nearest)
            incr = guard & (round | sticky | lsb);
        else
            incr = directed_up;
    end
endmodule

// File: rtl/rnd_carry_incr.sv
// Adds a single carry-in bit to a WIDTH-bit operand through an explicit
// ripple chain. Assumes the caller supplies headroom in the top bit,
// so no carry leaves the result.
module rnd_carry_incr #(
    parameter int WIDTH = 31
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Half-adder stage for bit i.
            assign sum[i]     = a[i] ^ carry[i];
            assign carry[i+1] = a[i] & carry[i];
        end
    endgenerate

    logic unused_cout;
    assign unused_cout = carry[WIDTH];
endmodule

// File: rtl/rnd_decision_unit.sv
// Top of the rounding decision unit. Splits the guard and round bits
// off the mantissa, shares one mode decode between the increment and
// the overflow decisions, and registers all results for one cycle.
// Assumes MANT_W >= 4. The carry out of the shifted mantissa lands in
// the top bit of out_mant and is not renormalised here.
module rnd_decision_unit
    import rnd_pkg::*;
#(
    parameter int MANT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [MANT_W-2:0] out_mant,
    output logic              out_inexact,
    output logic              out_rounded_up,
    output logic              out_to_inf
);
    localparam int SHIFT_W = MANT_W - 2;
    localparam int OUT_W   = SHIFT_W + 1;

    logic [SHIFT_W-1:0] shifted;
    logic [OUT_W-1:0]   widened;
    logic [OUT_W-1:0]   rounded;
    logic               nearest_w;
    logic               dir_up_w;
    logic               to_inf_w;
    logic               inexact_w;
    logic               incr_w;

    // Discard guard and round; leave one bit of headroom for the carry.
    always_comb begin
        shifted = in_mant[MANT_W-1:2];
        widened = {1'b0, shifted};
    end

    rnd_mode_decode u_decode (
        .mode        (rnd_mode_e'(in_mode)),
        .sign        (in_sign),
        .is_nearest  (nearest_w),
        .directed_up (dir_up_w),
        .to_inf      (to_inf_w)
    );

    rnd_incr_decide u_decide (
        .guard       (in_mant[1]),
        .round       (in_mant[0]),
        .sticky      (in_sticky),
        .lsb         (in_mant[2]),
        .is_nearest  (nearest_w),
        .directed_up (dir_up_w),
        .inexact     (inexact_w),
        .incr        (incr_w)
    );

    rnd_carry_incr #(.WIDTH(OUT_W)) u_incr (
        .a   (widened),
        .cin (incr_w),
        .sum (rounded)
    );

    // Strobe register: follows in_valid with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Result registers: load on a valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mant       <= '0;
            out_inexact    <= 1'b0;
            out_rounded_up <= 1'b0;
            out_to_inf     <= 1'b0;
        end else if (in_valid) begin
            out_mant       <= rounded;
            out_inexact    <= inexact_w;
            out_rounded_up <= incr_w;
            out_to_inf     <= to_inf_w;
        end
    end
endmodule

// File: rtl/rnd_decision_checker.sv
// Property checker for rnd_decision_unit, attached by bind below.
// Relates the input ports of one cycle to the registered outputs of the next.
module rnd_decision_checker #(
    parameter int MANT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sign,
    input logic [MANT_W-1:0] in_mant,
    input logic              in_sticky,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [MANT_W-2:0] out_mant,
    input logic              out_inexact,
    input logic              out_rounded_up,
    input logic              out_to_inf
);
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mant) && $stable(out_inexact) &&
                       $stable(out_rounded_up) && $stable(out_to_inf)));
    p_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mant[1:0] == 2'b00 && !in_sticky)
            |=> (!out_inexact && !out_rounded_up));
    p_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mant[1:0] != 2'b00 || in_sticky)) |=> out_inexact);
    p_nearest_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_rounded_up);
    p_zero_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=> (!out_rounded_up && !out_to_inf));
    p_pos_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10 && in_sign) |=> !out_rounded_up);
    p_neg_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11 && !in_sign) |=> !out_rounded_up);
    p_up_implies_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_rounded_up || out_inexact));
    p_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_mant == ({1'b0, $past(in_mant[MANT_W-1:2])} +
                                   (MANT_W-1)'(out_rounded_up))));
    p_inf_nearest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00) |=> out_to_inf);
    p_inf_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10) |=> (out_to_inf == !$past(in_sign)));
endmodule

bind rnd_decision_unit rnd_decision_checker #(.MANT_W(MANT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sign        (in_sign),
    .in_mant        (in_mant),
    .in_sticky      (in_sticky),
    .in_mode        (in_mode),
    .out_valid      (out_valid),
    .out_mant       (out_mant),
    .out_inexact    (out_inexact),
    .out_rounded_up (out_rounded_up),
    .out_to_inf     (out_to_inf)
);

// File: tb/rnd_decision_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes expected results and queues them,
// and the monitor compares each one when out_valid shows.
module rnd_decision_unit_test;
    localparam int MW = 32;
    localparam int OW = MW - 1;

    typedef struct {
        logic [OW-1:0] mant;
        logic          inexact;
        logic          up;
        logic          inf;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sign = 1'b0;
    logic [MW-1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic          out_valid;
    logic [OW-1:0] out_mant;
    logic          out_inexact;
    logic          out_rounded_up;
    logic          out_to_inf;

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    exp_t sb[$];
    exp_t last_exp;

    rnd_decision_unit #(.MANT_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_mant(in_mant), .in_sticky(in_sticky), .in_mode(in_mode),
        .out_valid(out_valid), .out_mant(out_mant), .out_inexact(out_inexact),
        .out_rounded_up(out_rounded_up), .out_to_inf(out_to_inf)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference model written from the requirements.
    function automatic exp_t model(input logic s, input logic [MW-1:0] m,
                                   input logic st, input logic [1:0] md,
                                   input string tag);
        exp_t e;
        logic g, r, lsb, inc;
        g = m[1]; r = m[0]; lsb = m[2];
        e.inexact = g | r | st;
        case (md)
            2'b00: begin inc = g & (r | st | lsb); e.inf = 1'b1; end
            2'b01: begin inc = 1'b0;               e.inf = 1'b0; end
            2'b10: begin inc = ~s;                 e.inf = ~s;   end
            default: begin inc = s;                e.inf = s;    end
        endcase
        inc    = inc & e.inexact;
        e.up   = inc;
        e.mant = {1'b0, m[MW-1:2]} + OW'(inc);
        e.tag  = tag;
        return e;
    endfunction

    task automatic drive(input logic s, input logic [MW-1:0] m, input logic st,
                         input logic [1:0] md, input string tag);
        exp_t e;
        @(negedge clk);
        e = model(s, m, st, md, tag);
        sb.push_back(e);
        last_exp  = e;
        in_valid  = 1'b1;
        in_sign   = s;
        in_mant   = m;
        in_sticky = st;
        in_mode   = md;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_mant  = 32'hDEAD_BEEF;
            in_sticky = 1'b1;
            in_mode  = 2'b10;
        end
    endtask

    // Monitor: pops and compares one expected item per output strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks = checks + 1;
            if (sb.size() == 0) begin
                errors = errors + 1;
                $display("FAIL R2: actual unexpected out_valid expected none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_mant !== e.mant || out_inexact !== e.inexact ||
                    out_rounded_up !== e.up || out_to_inf !== e.inf) begin
                    errors = errors + 1;
                    $display("FAIL %s: actual mant=%h ix=%b up=%b inf=%b expected mant=%h ix=%b up=%b inf=%b",
                             e.tag, out_mant, out_inexact, out_rounded_up, out_to_inf,
                             e.mant, e.inexact, e.up, e.inf);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks = checks + 1;
        if (out_valid !== 1'b0 || out_mant !== '0 || out_inexact !== 1'b0 ||
            out_rounded_up !== 1'b0 || out_to_inf !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1: actual v=%b mant=%h expected all zero", out_valid, out_mant);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks = checks + 1;
        if (out_valid !== 1'b0 || out_mant !== '0) begin
            errors = errors + 1;
            $display("FAIL R1: actual v=%b mant=%h after release expected 0", out_valid, out_mant);
        end

        drive(1'b0, 32'h0000_0010, 1'b0, 2'b00, "R3");  // exact, out 4
        drive(1'b1, 32'h1234_5670, 1'b0, 2'b10, "R3");  // exact in directed mode
        drive(1'b0, 32'h0000_0020, 1'b1, 2'b00, "R4");  // sticky only
        drive(1'b0, 32'h0000_0001, 1'b0, 2'b00, "R4");  // round only, no inc
        drive(1'b0, 32'h0000_0002, 1'b0, 2'b00, "R5");  // tie, even, stays 0
        drive(1'b0, 32'h0000_0006, 1'b0, 2'b00, "R5");  // tie, odd, to 2
        drive(1'b1, 32'h0000_0003, 1'b0, 2'b00, "R5");  // above half
        drive(1'b0, 32'h0000_0002, 1'b1, 2'b00, "R5");  // guard and sticky
        drive(1'b0, 32'h0000_0007, 1'b1, 2'b01, "R6");
        drive(1'b1, 32'hFFFF_FFFF, 1'b1, 2'b01, "R6");
        drive(1'b0, 32'h0000_0001, 1'b0, 2'b10, "R7");
        drive(1'b1, 32'h0000_0001, 1'b0, 2'b10, "R7");
        drive(1'b1, 32'h0000_0100, 1'b1, 2'b11, "R8");
        drive(1'b0, 32'h0000_0100, 1'b1, 2'b11, "R8");
        drive(1'b0, 32'hFFFF_FFFF, 1'b0, 2'b00, "R9");  // carry to top bit
        drive(1'b0, 32'h0000_FFFE, 1'b0, 2'b00, "R9");  // ripple across 14 bits
        drive(1'b1, 32'hFFFF_FFFC, 1'b0, 2'b11, "R10"); // exact, to_inf = sign
        drive(1'b0, 32'hFFFF_FFFC, 1'b0, 2'b11, "R10");
        drive(1'b1, 32'h8000_0000, 1'b0, 2'b00, "R10");
        idle(1);

        // R2 hold: after idle cycles with noisy inputs the outputs keep the last result
        idle(3);
        checks = checks + 1;
        if (out_valid !== 1'b0 || out_mant !== last_exp.mant ||
            out_to_inf !== last_exp.inf || out_inexact !== last_exp.inexact) begin
            errors = errors + 1;
            $display("FAIL R2: actual v=%b mant=%h inf=%b expected v=0 mant=%h inf=%b",
                     out_valid, out_mant, out_to_inf, last_exp.mant, last_exp.inf);
        end
        checks = checks + 1;
        if (sb.size() != 0) begin
            errors = errors + 1;
            $display("FAIL R2: actual %0d pending results expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule